// File: doc/BRIEF.md
# Byte-Serial SPI Port (Master or Slave)

This block is a single-lane SPI port that a processor drives through a small register bus. The bus has an address, a write strobe, a read strobe, 8-bit write data and 16-bit read data. One control bit selects the role. As master, the port produces the serial clock and one chip-select line, and it exchanges 1 to 8 bits per transfer. The bit rate comes from a 16-bit divider that is written as two byte-wide registers. As slave, the port takes the external serial clock, select and data lines into the system clock domain through synchronisers. It detects clock edges on those samples, so it has no second clock domain. For this reason the external serial clock must run below one eighth of the system clock.

Software starts a master transfer by writing the data register. It then either waits for the interrupt or polls the busy bit, and reads the received bits back from the same address. Clock polarity, clock phase, automatic or manual chip-select drive and chip-select inversion are programmable. Two sticky status flags, transfer done and overrun, are cleared by writing 1 to them. The interrupt output is the done flag gated by an enable bit.

Register map (address on `bus_addr`): 0 data, 1 control, 2 status, 3 select/count, 4 divider low byte, 5 divider high byte.
Control bits: 0 master, 1 clock polarity, 2 clock phase, 3 chip-select invert, 4 automatic chip-select, 5 interrupt enable.
Status bits: 0 done, 1 overrun, 2 busy (read only).
Select/count bits: 2:0 bit count, 3 manual select.

Top module: `spi_port`

## Requirements
- R1: After reset, the following read as zero: control, status, select/count and both divider registers. `m_sclk_o` is 0, `m_cs_o` is 1 and `irq_o` is 0.
- R2: In master mode, a write to the data register while the port is idle sends the top N bits of the byte MSB first on `m_mosi_o`. N is bits 2:0 of select/count, and a count of 0 means 8. The N received bits are returned right-aligned in the data register, with the first received bit at position N-1 and the upper bits zero.
- R3: A master transfer produces exactly 2N serial clock edges. Between transfers `m_sclk_o` rests at the clock polarity bit. With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R4: Each half period of the master serial clock lasts D+1 system clocks. D is the 16-bit value formed from divider high byte (bits 15:8) and divider low byte (bits 7:0).
- R5: With automatic chip-select on, `m_cs_o` is driven low while a master transfer runs and high otherwise. With automatic chip-select off, `m_cs_o` is low exactly when the manual select bit is 1. The invert bit flips the pin level in both cases.
- R6: The done flag is set when a master transfer ends. `irq_o` equals the done flag AND the interrupt enable. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: The overrun flag is set when a new received byte completes while the previous one has not been read. Reading the data register marks the byte as read. The data register always holds the newest byte.
- R8: The busy bit is 1 while a master transfer runs, or while the slave select is active in slave mode. In master mode, a data write made while busy is ignored.
- R9: In slave mode, with `s_cs_n_i` low, the port applies the same phase and polarity rules to the sampled `s_sclk_i`. It receives N bits from `s_mosi_i` into the data register, right-aligned. It shifts the last written data byte out MSB first on `s_miso_o`.
- R10: In slave mode, a low-to-high change of `s_cs_n_i` sets the done flag. A completed byte on its own does not set it.
- R11: Unused bits read as zero. This covers control bits 7:6, select/count bits 7:4, status bits 7:3 and bits 15:8 of every 8-bit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of address 0 marks received data as read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| m_sclk_o | output | 1 | Master serial clock |
| m_mosi_o | output | 1 | Master serial data out |
| m_miso_i | input | 1 | Master serial data in |
| m_cs_o | output | 1 | Master chip select |
| s_sclk_i | input | 1 | Slave serial clock (asynchronous) |
| s_cs_n_i | input | 1 | Slave select, active low (asynchronous) |
| s_mosi_i | input | 1 | Slave serial data in (asynchronous) |
| s_miso_o | output | 1 | Slave serial data out |
| irq_o | output | 1 | Interrupt request |

## Verification
The master path is exercised with `m_mosi_o` looped back to `m_miso_i`. A byte table covers all four polarity and phase combinations, bit counts of 1, 3, 5, 7 and 8, and dividers from 0 up to a value with a non-zero high byte. A wrong sampling edge, wrong bit order or wrong alignment therefore shows up in the returned value. Counts of serial clock edges and measured half periods separate length errors from divider errors. The idle clock level exposes polarity mistakes. Slave mode is driven by a slow external clock in phase 0 with polarity 0, and in phase 1 with polarity 1. Checking both the received byte and the bits seen on `s_miso_o` separates receive-side faults from transmit-side faults.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;

   typedef enum logic [2:0] {
      RA_DATA = 3'd0,
      RA_CTRL = 3'd1,
      RA_STAT = 3'd2,
      RA_SELC = 3'd3,
      RA_DIVL = 3'd4,
      RA_DIVH = 3'd5
   } reg_addr_e;

   // packed MSB first: bit 0 is master
   typedef struct packed {
      logic irq_en;
      logic auto_cs;
      logic cs_inv;
      logic cpha;
      logic cpol;
      logic master;
   } ctrl_t;

   localparam int unsigned CTRL_BITS = $bits(ctrl_t);

endpackage

// File: rtl/spi_port_divider.sv
`timescale 1ns/1ps
module spi_port_divider #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run_i || tick_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + DIV_W'(1);
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && tick_o && div_i != '0) |=> !tick_o); // R4

endmodule

// File: rtl/spi_port_master.sv
`timescale 1ns/1ps
module spi_port_master #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [BYTE_W-1:0]          tx_i,
   input  logic [$clog2(BYTE_W):0]    nbits_i,
   input  logic                       cpha_i,
   input  logic                       tick_i,
   input  logic                       miso_i,
   output logic                       busy_o,
   output logic                       sclk_o,
   output logic                       mosi_o,
   output logic                       done_o,
   output logic [BYTE_W-1:0]          rx_o
);

   localparam int unsigned CNT_W  = $clog2(BYTE_W);
   localparam int unsigned EDGE_W = CNT_W + 2;

   logic              busy_q, sclk_q, done_q;
   logic [EDGE_W-1:0] edge_q;
   logic [CNT_W:0]    nb_q;
   logic [BYTE_W-1:0] txsr_q, rxsr_q;
   logic [EDGE_W-1:0] edge_end;
   logic              lead, last, sample;

   assign edge_end = {nb_q, 1'b0};
   assign last     = (edge_q == edge_end - EDGE_W'(1));
   assign lead     = ~edge_q[0];
   assign sample   = lead ^ cpha_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
         edge_q <= '0;
         nb_q   <= '0;
         txsr_q <= '0;
         rxsr_q <= '0;
      end else begin
         done_q <= busy_q && tick_i && last;
         if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            edge_q <= '0;
            nb_q   <= nbits_i;
            txsr_q <= tx_i;
            rxsr_q <= '0;
         end else if (busy_q && tick_i) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + EDGE_W'(1);
            if (sample)
               rxsr_q <= {rxsr_q[BYTE_W-2:0], miso_i};
            else if (edge_q != '0)
               txsr_q <= {txsr_q[BYTE_W-2:0], 1'b0};
            if (last) busy_q <= 1'b0;
         end
      end
   end

   assign busy_o = busy_q;
   assign sclk_o = sclk_q;
   assign mosi_o = txsr_q[BYTE_W-1];
   assign done_o = done_q;
   assign rx_o   = rxsr_q;

   AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (edge_q < edge_end)); // R2
   AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sclk_q); // R3
   AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R6

endmodule

// File: rtl/spi_port_slave.sv
`timescale 1ns/1ps
module spi_port_slave #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en_i,
   input  logic                    cpol_i,
   input  logic                    cpha_i,
   input  logic [$clog2(BYTE_W):0] nbits_i,
   input  logic [BYTE_W-1:0]       tx_i,
   input  logic                    sclk_i,
   input  logic                    cs_n_i,
   input  logic                    mosi_i,
   output logic                    miso_o,
   output logic                    active_o,
   output logic                    rx_evt_o,
   output logic [BYTE_W-1:0]       rx_o,
   output logic                    rel_evt_o
);

   localparam int unsigned CNT_W = $clog2(BYTE_W);
   localparam logic [2:0]  SYNC_RST = 3'b010; // sclk 0, select idle, data 0

   logic [2:0]        stg_q [SYNC_STAGES];
   logic              sck, csn, sdi;
   logic              sck_q, act_q, act;
   logic              chg, lead, trail, do_sample, do_shift;
   logic [CNT_W:0]    bit_q;
   logic [BYTE_W-1:0] sr_q, rxsr_q, rx_q;
   logic              rx_evt_q, rel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) stg_q[s] <= SYNC_RST;
      end else begin
         stg_q[0] <= {sclk_i, cs_n_i, mosi_i};
         for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign {sck, csn, sdi} = stg_q[SYNC_STAGES-1];
   assign act       = en_i && !csn;
   assign chg       = (sck != sck_q);
   assign lead      = chg && (sck != cpol_i);
   assign trail     = chg && (sck == cpol_i);
   assign do_sample = cpha_i ? trail : lead;
   assign do_shift  = cpha_i ? lead : trail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q    <= 1'b0;
         act_q    <= 1'b0;
         bit_q    <= '0;
         sr_q     <= '0;
         rxsr_q   <= '0;
         rx_q     <= '0;
         rx_evt_q <= 1'b0;
         rel_q    <= 1'b0;
      end else begin
         sck_q    <= sck;
         act_q    <= act;
         rx_evt_q <= 1'b0;
         rel_q    <= act_q && !act;
         if (act && !act_q) begin
            sr_q   <= tx_i;
            bit_q  <= '0;
            rxsr_q <= '0;
         end else if (act) begin
            if (do_sample) begin
               if (bit_q == nbits_i - (CNT_W+1)'(1)) begin
                  bit_q    <= '0;
                  rx_q     <= {rxsr_q[BYTE_W-2:0], sdi};
                  rx_evt_q <= 1'b1;
                  rxsr_q   <= '0;
                  if (cpha_i) sr_q <= tx_i;
               end else begin
                  bit_q  <= bit_q + (CNT_W+1)'(1);
                  rxsr_q <= {rxsr_q[BYTE_W-2:0], sdi};
               end
            end else if (do_shift) begin
               if (bit_q == '0) begin
                  if (!cpha_i) sr_q <= tx_i;
               end else begin
                  sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign miso_o    = act ? sr_q[BYTE_W-1] : 1'b0;
   assign active_o  = act;
   assign rx_evt_o  = rx_evt_q;
   assign rx_o      = rx_q;
   assign rel_evt_o = rel_q;

   AST_SLV_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> (bit_q < nbits_i)); // R9
   AST_SLV_REL_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rel_q) |-> $past(act_q)); // R10

endmodule

// File: rtl/spi_port_regs.sv
`timescale 1ns/1ps
module spi_port_regs
   import spi_port_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned BUS_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [2:0]              bus_addr,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   input  logic [BYTE_W-1:0]       bus_wdata,
   output logic [BUS_W-1:0]        bus_rdata,
   output ctrl_t                   ctrl_o,
   output logic [$clog2(BYTE_W)-1:0] cnt_o,
   output logic                    man_sel_o,
   output logic [DIV_W-1:0]        div_o,
   output logic [BYTE_W-1:0]       tx_o,
   output logic                    start_o,
   output logic                    done_flag_o,
   input  logic                    busy_i,
   input  logic                    done_evt_i,
   input  logic                    rx_evt_i,
   input  logic [BYTE_W-1:0]       rx_byte_i
);

   localparam int unsigned CNT_W = $clog2(BYTE_W);
   localparam int unsigned HI_W  = DIV_W - BYTE_W;

   ctrl_t             ctrl_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              sel_q;
   logic [DIV_W-1:0]  div_q;
   logic [BYTE_W-1:0] tx_q, rx_q;
   logic              full_q, done_q, ovr_q;
   logic              wr_data, wr_stat, rd_data;

   assign wr_data = bus_wr && (bus_addr == RA_DATA);
   assign wr_stat = bus_wr && (bus_addr == RA_STAT);
   assign rd_data = bus_rd && (bus_addr == RA_DATA);
   assign start_o = wr_data && ctrl_q.master && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cnt_q  <= '0;
         sel_q  <= 1'b0;
         div_q  <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         full_q <= 1'b0;
         done_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (bus_wr) begin
            unique case (bus_addr)
               RA_CTRL: ctrl_q <= ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
               RA_SELC: begin
                  cnt_q <= bus_wdata[CNT_W-1:0];
                  sel_q <= bus_wdata[CNT_W];
               end
               RA_DIVL: div_q[BYTE_W-1:0]     <= bus_wdata;
               RA_DIVH: div_q[DIV_W-1:BYTE_W] <= bus_wdata[HI_W-1:0];
               RA_DATA: if (!(ctrl_q.master && busy_i)) tx_q <= bus_wdata;
               default: ;
            endcase
         end
         done_q <= (done_q && !(wr_stat && bus_wdata[0])) || done_evt_i;
         ovr_q  <= (ovr_q && !(wr_stat && bus_wdata[1]))
                   || (rx_evt_i && full_q && !rd_data);
         if (rx_evt_i) begin
            rx_q   <= rx_byte_i;
            full_q <= 1'b1;
         end else if (rd_data) begin
            full_q <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         RA_DATA: bus_rdata[BYTE_W-1:0]    = rx_q;
         RA_CTRL: bus_rdata[CTRL_BITS-1:0] = ctrl_q;
         RA_STAT: bus_rdata[2:0]           = {busy_i, ovr_q, done_q};
         RA_SELC: bus_rdata[CNT_W:0]       = {sel_q, cnt_q};
         RA_DIVL: bus_rdata[BYTE_W-1:0]    = div_q[BYTE_W-1:0];
         RA_DIVH: bus_rdata[HI_W-1:0]      = div_q[DIV_W-1:BYTE_W];
         default: bus_rdata = '0;
      endcase
   end

   assign ctrl_o      = ctrl_q;
   assign cnt_o       = cnt_q;
   assign man_sel_o   = sel_q;
   assign div_o       = div_q;
   assign tx_o        = tx_q;
   assign done_flag_o = done_q;

   AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(full_q)); // R7
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !wr_stat) |=> done_q); // R6

endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
   import spi_port_pkg::*;
#(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned BUS_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              m_sclk_o,
   output logic              m_mosi_o,
   input  logic              m_miso_i,
   output logic              m_cs_o,
   input  logic              s_sclk_i,
   input  logic              s_cs_n_i,
   input  logic              s_mosi_i,
   output logic              s_miso_o,
   output logic              irq_o
);

   localparam int unsigned CNT_W = $clog2(BYTE_W);

   if (BYTE_W < 8 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_byte
      $error("BYTE_W must be a power of two of at least 8");
   end
   if (DIV_W <= BYTE_W || DIV_W > 2 * BYTE_W) begin : g_bad_div
      $error("DIV_W must lie between BYTE_W+1 and 2*BYTE_W");
   end
   if (BUS_W < BYTE_W) begin : g_bad_bus
      $error("BUS_W must be at least BYTE_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   ctrl_t             ctrl;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W:0]    nbits;
   logic              man_sel, start, done_flag, tick;
   logic [DIV_W-1:0]  div;
   logic [BYTE_W-1:0] tx_buf, m_rx, s_rx, rx_byte;
   logic              m_busy, m_sclk_raw, m_done;
   logic              s_act, s_rx_evt, s_rel;
   logic              busy, cs_assert;

   assign nbits = (cnt == '0) ? (CNT_W+1)'(BYTE_W) : {1'b0, cnt};

   spi_port_regs #(.BYTE_W(BYTE_W), .DIV_W(DIV_W), .BUS_W(BUS_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ctrl_o(ctrl), .cnt_o(cnt), .man_sel_o(man_sel), .div_o(div),
      .tx_o(tx_buf), .start_o(start), .done_flag_o(done_flag),
      .busy_i(busy), .done_evt_i(m_done || s_rel),
      .rx_evt_i(m_done || s_rx_evt), .rx_byte_i(rx_byte)
   );

   spi_port_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run_i(m_busy), .div_i(div), .tick_o(tick)
   );

   spi_port_master #(.BYTE_W(BYTE_W)) u_mst (
      .clk(clk), .rst_n(rst_n),
      .start_i(start), .tx_i(bus_wdata), .nbits_i(nbits), .cpha_i(ctrl.cpha),
      .tick_i(tick), .miso_i(m_miso_i),
      .busy_o(m_busy), .sclk_o(m_sclk_raw), .mosi_o(m_mosi_o),
      .done_o(m_done), .rx_o(m_rx)
   );

   spi_port_slave #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_slv (
      .clk(clk), .rst_n(rst_n), .en_i(!ctrl.master),
      .cpol_i(ctrl.cpol), .cpha_i(ctrl.cpha), .nbits_i(nbits), .tx_i(tx_buf),
      .sclk_i(s_sclk_i), .cs_n_i(s_cs_n_i), .mosi_i(s_mosi_i),
      .miso_o(s_miso_o), .active_o(s_act),
      .rx_evt_o(s_rx_evt), .rx_o(s_rx), .rel_evt_o(s_rel)
   );

   assign busy      = ctrl.master ? m_busy : s_act;
   assign rx_byte   = ctrl.master ? m_rx : s_rx;
   assign cs_assert = ctrl.auto_cs ? (ctrl.master && m_busy) : man_sel;
   assign m_cs_o    = ctrl.cs_inv ? cs_assert : ~cs_assert;
   assign m_sclk_o  = ctrl.master ? (m_sclk_raw ^ ctrl.cpol) : ctrl.cpol;
   assign irq_o     = done_flag && ctrl.irq_en;

   AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.master && !m_busy) |-> (m_sclk_o == ctrl.cpol)); // R3
   AST_CS_AUTO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.auto_cs && ctrl.master && m_busy) |-> (m_cs_o == ctrl.cs_inv)); // R5
   AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      m_done |=> done_flag); // R6
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !done_flag |-> !irq_o); // R6

endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        m_sclk_o, m_mosi_o, m_cs_o, s_miso_o, irq_o;
   logic        s_sclk = 1'b0, s_cs_n = 1'b1, s_mosi = 1'b0;

   int n_tests = 0, n_fail = 0;

   always #10 clk = ~clk;

   spi_port dut (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .m_sclk_o(m_sclk_o), .m_mosi_o(m_mosi_o), .m_miso_i(m_mosi_o), .m_cs_o(m_cs_o),
      .s_sclk_i(s_sclk), .s_cs_n_i(s_cs_n), .s_mosi_i(s_mosi), .s_miso_o(s_miso_o),
      .irq_o(irq_o)
   );

   // serial clock monitor
   logic prev_sclk = 1'b0;
   int   toggles = 0, gap_cnt = 0, last_gap = 0;
   always @(negedge clk) begin
      gap_cnt = gap_cnt + 1;
      if (m_sclk_o !== prev_sclk) begin
         toggles  = toggles + 1;
         last_gap = gap_cnt;
         gap_cnt  = 0;
      end
      prev_sclk = m_sclk_o;
   end

   localparam logic [2:0] A_DATA = 3'd0, A_CTRL = 3'd1, A_STAT = 3'd2,
                          A_SELC = 3'd3, A_DIVL = 3'd4, A_DIVH = 3'd5;

   // {cpol, cpha, count[2:0], 3'b0, tx[7:0], div[15:0]}
   localparam logic [31:0] VEC [6] = '{
      {1'b0, 1'b0, 3'd0, 3'd0, 8'hA5, 16'd2},
      {1'b1, 1'b0, 3'd0, 3'd0, 8'h3C, 16'd0},
      {1'b0, 1'b1, 3'd5, 3'd0, 8'hD8, 16'd1},
      {1'b1, 1'b1, 3'd1, 3'd0, 8'h80, 16'd3},
      {1'b0, 1'b0, 3'd3, 3'd0, 8'h6F, 16'h0100},
      {1'b1, 1'b1, 3'd7, 3'd0, 8'hFE, 16'd4}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wait_irq(input string tag);
      int guard = 0;
      while (!irq_o && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      chk(tag, int'(irq_o), 1);
   endtask

   task automatic wait_idle();
      logic [15:0] s;
      int guard = 0;
      rd(A_STAT, s);
      while (s[2] && guard < 5000) begin
         rd(A_STAT, s);
         guard++;
      end
   endtask

   task automatic slave_xfer(input logic cpol, input logic cpha, input int n,
                             input logic [7:0] mo, output logic [7:0] mi);
      mi = '0;
      for (int i = 0; i < n; i++) begin
         if (!cpha) begin
            s_mosi = mo[7-i];
            repeat (8) @(negedge clk);
            mi = {mi[6:0], s_miso_o};
            s_sclk = ~cpol;
            repeat (8) @(negedge clk);
            s_sclk = cpol;
         end else begin
            s_sclk = ~cpol;
            s_mosi = mo[7-i];
            repeat (8) @(negedge clk);
            mi = {mi[6:0], s_miso_o};
            s_sclk = cpol;
            repeat (8) @(negedge clk);
         end
      end
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  mi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      rd(A_CTRL, v); chk("R1 ctrl", v, 0);
      rd(A_STAT, v); chk("R1 stat", v, 0);
      rd(A_SELC, v); chk("R1 selc", v, 0);
      rd(A_DIVL, v); chk("R1 divl", v, 0);
      rd(A_DIVH, v); chk("R1 divh", v, 0);
      chk("R1 sclk", int'(m_sclk_o), 0);
      chk("R1 cs", int'(m_cs_o), 1);
      chk("R1 irq", int'(irq_o), 0);

      // R11 reserved bits
      wr(A_CTRL, 8'hFF); rd(A_CTRL, v); chk("R11 ctrl", v, 16'h003F);
      wr(A_SELC, 8'hFF); rd(A_SELC, v); chk("R11 selc", v, 16'h000F);
      wr(A_DIVH, 8'hFF); rd(A_DIVH, v); chk("R11 divh", v, 16'h00FF);
      wr(A_SELC, 8'h00); wr(A_CTRL, 8'h00);

      // R2 R3 R4 R5 R8 vector table with loopback
      for (int i = 0; i < 6; i++) begin
         logic [31:0] e;
         logic [2:0]  c;
         int          n, base, guard;
         e = VEC[i];
         c = e[29:27];
         n = (c == 0) ? 8 : int'(c);
         wr(A_DIVL, e[7:0]);
         wr(A_DIVH, e[15:8]);
         wr(A_SELC, {5'd0, c});
         wr(A_CTRL, 8'h31 | {5'd0, e[30], e[31], 1'b0});
         repeat (2) @(negedge clk);
         base = toggles;
         wr(A_DATA, e[23:16]);
         guard = 0;
         while (toggles == base && guard < 2000) begin @(negedge clk); guard++; end
         chk("R5 cs active", int'(m_cs_o), 0);
         rd(A_STAT, v); chk("R8 busy", int'(v[2]), 1);
         wait_irq("R6 irq");
         rd(A_DATA, v); chk("R2 rx", v, int'(e[23:16] >> (8 - n)));
         chk("R3 edges", toggles - base, 2 * n);
         chk("R3 idle", int'(m_sclk_o), int'(e[31]));
         chk("R4 half", last_gap, int'(e[15:0]) + 1);
         chk("R5 cs idle", int'(m_cs_o), 1);
         wr(A_STAT, 8'h01);
         chk("R6 clear", int'(irq_o), 0);
      end

      // R8 write while busy ignored
      wr(A_DIVH, 8'h00); wr(A_DIVL, 8'h03); wr(A_SELC, 8'h00); wr(A_CTRL, 8'h31);
      wr(A_DATA, 8'hC3);
      repeat (20) @(negedge clk);
      wr(A_DATA, 8'h55);
      wait_irq("R8 irq");
      rd(A_DATA, v); chk("R8 ignored", v, 16'h00C3);
      wr(A_STAT, 8'h01);

      // R7 overrun
      wr(A_DIVL, 8'h00);
      wr(A_DATA, 8'h11); wait_irq("R7 first");
      wr(A_STAT, 8'h01);
      wr(A_DATA, 8'h22); wait_irq("R7 second");
      rd(A_STAT, v); chk("R7 ovr", v, 16'h0003);
      rd(A_DATA, v); chk("R7 newest", v, 16'h0022);
      wr(A_STAT, 8'h02); rd(A_STAT, v); chk("R6 w1c bit", v, 16'h0001);
      wr(A_STAT, 8'h00); rd(A_STAT, v); chk("R6 w0 keeps", v, 16'h0001);
      wr(A_STAT, 8'h01); rd(A_STAT, v); chk("R6 cleared", v, 0);

      // R6 irq gated by enable
      wr(A_CTRL, 8'h11);
      wr(A_DATA, 8'h5A); wait_idle();
      rd(A_STAT, v); chk("R6 flag set", int'(v[0]), 1);
      chk("R6 irq gated", int'(irq_o), 0);
      rd(A_DATA, v); wr(A_STAT, 8'h01);

      // R5 manual select and inversion
      wr(A_CTRL, 8'h01); wr(A_SELC, 8'h08);
      chk("R5 manual on", int'(m_cs_o), 0);
      wr(A_SELC, 8'h00);
      chk("R5 manual off", int'(m_cs_o), 1);
      wr(A_CTRL, 8'h09);
      chk("R5 inverted idle", int'(m_cs_o), 0);

      // R9 R10 slave, polarity 0 phase 0, 8 bits
      wr(A_CTRL, 8'h20); wr(A_SELC, 8'h00); wr(A_DATA, 8'h3C); wr(A_STAT, 8'h03);
      s_cs_n = 1'b0;
      repeat (8) @(negedge clk);
      rd(A_STAT, v); chk("R8 slave busy", int'(v[2]), 1);
      slave_xfer(1'b0, 1'b0, 8, 8'hA5, mi);
      chk("R9 miso", mi, 8'h3C);
      rd(A_STAT, v); chk("R10 no done yet", int'(v[0]), 0);
      rd(A_DATA, v); chk("R9 rx", v, 16'h00A5);
      s_cs_n = 1'b1;
      repeat (8) @(negedge clk);
      chk("R10 release irq", int'(irq_o), 1);
      wr(A_STAT, 8'h03);

      // R9 slave, polarity 1 phase 1, 4 bits
      s_sclk = 1'b1;
      wr(A_CTRL, 8'h26); wr(A_SELC, 8'h04); wr(A_DATA, 8'h6A);
      repeat (8) @(negedge clk);
      s_cs_n = 1'b0;
      repeat (8) @(negedge clk);
      slave_xfer(1'b1, 1'b1, 4, 8'h9C, mi);
      chk("R9 miso mode3", mi, 8'h06);
      rd(A_DATA, v); chk("R9 rx mode3", v, 16'h0009);
      s_cs_n = 1'b1;
      repeat (8) @(negedge clk);
      rd(A_STAT, v); chk("R10 release mode3", int'(v[0]), 1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule